// File: doc/BRIEF.md
# Odd-Parity Single-Error-Correcting Hamming Decoder (13-bit)

This block accepts a 13-bit Hamming word whose check groups were set up for odd parity. Positions are numbered 1 to 13. Check bits sit at the power-of-two positions 1, 2, 4 and 8, and nine payload bits fill the other positions. For each received word the block evaluates the four check groups and assembles a 4-bit syndrome. When the syndrome names a position inside the word, that bit is inverted. The block then presents the repaired word, the nine payload bits, the syndrome and the status flags one clock later.

Input is qualified by a valid bit. Each accepted word produces exactly one output strobe on the following cycle, and the result registers keep their contents until the next accepted word. A syndrome of 14 or 15 cannot name a bit of a 13-position word. Such a word is reported as uncorrectable and is passed through untouched.

Top module: `hamm13_odd_dec`

## Requirements
- R1: Input bit `cw_i[p-1]` is codeword position p (p = 1..13), so position 13 is the MSB. Positions 1, 2, 4 and 8 are check bits.
- R2: Check k (k = 0..3) covers every position whose number has bit k set. A check fails when its covered bits hold an even number of ones. `syn_o[k]` is 1 for a failing check, so `syn_o` = {check8, check4, check2, check1} read as an unsigned number.
- R3: A zero syndrome gives `cw_o` equal to the received word, with `err_o` = 0 and `uncorr_o` = 0.
- R4: A syndrome of 1 to 13 inverts exactly that position in `cw_o`, with `err_o` = 1 and `uncorr_o` = 0. For example, received 13'b0011100101101 gives syndrome 7 and output 13'b0011101101101.
- R5: A syndrome of 14 or 15 sets `err_o` = 1 and `uncorr_o` = 1, and leaves `cw_o` equal to the received word.
- R6: `data_o[0]` through `data_o[8]` carry corrected positions 3, 5, 6, 7, 9, 10, 11, 12 and 13 in that order, LSB first.
- R7: `vld_o` is `vld_i` delayed by one clock. In a cycle after `vld_i` was low, all result outputs keep their previous values.
- R8: A synchronous reset drives `vld_o`, `cw_o`, `data_o`, `syn_o`, `err_o` and `uncorr_o` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Input word valid |
| cw_i | input | 13 | Received codeword, bit p-1 = position p |
| vld_o | output | 1 | Result valid, one clock after vld_i |
| cw_o | output | 13 | Corrected codeword |
| data_o | output | 9 | Extracted payload bits |
| syn_o | output | 4 | Syndrome {check8, check4, check2, check1} |
| err_o | output | 1 | Syndrome non-zero |
| uncorr_o | output | 1 | Syndrome points outside the word |

## Verification
The bound checker checks the following properties on every cycle:
- the one-cycle valid delay and the holding of results while no word is accepted;
- that a clean word passes through unchanged;
- that a correctable word differs from its input in exactly one bit;
- that an uncorrectable word leaves the word intact and sets the error flag;
- that the payload matches the corrected word;
- the state after reset.

Some behaviours can be shown only by the bench's scenarios against its own parity model:
- that the syndrome value is right for a given word;
- that the inverted bit is the one the syndrome names, at every one of the thirteen positions;
- that double errors landing on syndromes 14 and 15 are classified as uncorrectable.

// File: rtl/hd13_pkg.sv
package hd13_pkg;

   // Largest supported word; bounds the constant search below.
   localparam int MAX_POS = 120;

   function automatic bit is_pow2(input int p);
      return (p > 0) && ((p & (p - 1)) == 0);
   endfunction

   // Position (1-based) of the j-th payload bit, counting from 0:
   // payload bits fill the non-power-of-two positions in rising order.
   function automatic int data_pos(input int j);
      int cnt;
      int res;
      cnt = 0;
      res = 0;
      for (int p = 1; p <= MAX_POS; p++) begin
         if (!is_pow2(p)) begin
            if (cnt == j && res == 0) res = p;
            cnt++;
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/hd_syndrome.sv
module hd_syndrome #(
   parameter int CW_W  = 13,
   parameter int CHK_W = 4,
   parameter bit ODD   = 1'b1
) (
   input  logic [CW_W-1:0]  cw,
   output logic [CHK_W-1:0] syn
);
   // Coverage mask of check k: positions whose number has bit k set.
   function automatic logic [CW_W-1:0] grp_mask(input int k);
      logic [CW_W-1:0] m;
      for (int i = 0; i < CW_W; i++) m[i] = (((i + 1) >> k) % 2) == 1;
      return m;
   endfunction

   for (genvar k = 0; k < CHK_W; k++) begin : g_chk
      localparam logic [CW_W-1:0] MASK = grp_mask(k);
      logic par;
      assign par = ^(cw & MASK);
      if (ODD) begin : g_odd
         // Odd parity: an even ones count is a failure.
         assign syn[k] = ~par;
      end else begin : g_even
         assign syn[k] = par;
      end
   end
endmodule

// File: rtl/hd_correct.sv
module hd_correct #(
   parameter int CW_W  = 13,
   parameter int CHK_W = 4
) (
   input  logic [CW_W-1:0]  cw,
   input  logic [CHK_W-1:0] syn,
   output logic [CW_W-1:0]  cw_fix,
   output logic             err,
   output logic             uncorr
);
   localparam int FULL = (1 << CHK_W) - 1;
   localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(CW_W);

   logic [CW_W-1:0] flip;

   // One decoder line per position.
   for (genvar i = 0; i < CW_W; i++) begin : g_pos
      assign flip[i] = (syn == CHK_W'(i + 1));
   end

   if (CW_W == FULL) begin : g_perfect
      // Every syndrome names a position.
      assign uncorr = 1'b0;
   end else begin : g_short
      assign uncorr = (syn > LAST_POS);
   end

   assign err    = |syn;
   assign cw_fix = cw ^ flip;
endmodule

// File: rtl/hd_extract.sv
module hd_extract #(
   parameter int CW_W  = 13,
   parameter int DAT_W = 9
) (
   input  logic [CW_W-1:0]  cw,
   output logic [DAT_W-1:0] dat
);
   for (genvar j = 0; j < DAT_W; j++) begin : g_dat
      localparam int P = hd13_pkg::data_pos(j);
      assign dat[j] = cw[P-1];
   end
endmodule

// File: rtl/hamm13_odd_dec.sv
module hamm13_odd_dec #(
   parameter int CW_W       = 13,
   parameter bit ODD_PARITY = 1'b1,
   localparam int CHK_W     = $clog2(CW_W + 1),
   localparam int DAT_W     = CW_W - CHK_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             vld_i,
   input  logic [CW_W-1:0]  cw_i,
   output logic             vld_o,
   output logic [CW_W-1:0]  cw_o,
   output logic [DAT_W-1:0] data_o,
   output logic [CHK_W-1:0] syn_o,
   output logic             err_o,
   output logic             uncorr_o
);
   if (CW_W < 3 || CW_W > hd13_pkg::MAX_POS) begin : g_bad_width
      $error("hamm13_odd_dec: CW_W out of range");
   end
   if (hd13_pkg::data_pos(DAT_W - 1) != CW_W && !hd13_pkg::is_pow2(CW_W)) begin : g_bad_map
      $error("hamm13_odd_dec: payload map inconsistent");
   end

   logic [CHK_W-1:0] syn_c;
   logic [CW_W-1:0]  fix_c;
   logic [DAT_W-1:0] dat_c;
   logic             err_c;
   logic             unc_c;

   hd_syndrome #(.CW_W(CW_W), .CHK_W(CHK_W), .ODD(ODD_PARITY)) syn_i (
      .cw  (cw_i),
      .syn (syn_c)
   );

   hd_correct #(.CW_W(CW_W), .CHK_W(CHK_W)) cor_i (
      .cw     (cw_i),
      .syn    (syn_c),
      .cw_fix (fix_c),
      .err    (err_c),
      .uncorr (unc_c)
   );

   hd_extract #(.CW_W(CW_W), .DAT_W(DAT_W)) ext_i (
      .cw  (fix_c),
      .dat (dat_c)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vld_o    <= 1'b0;
         cw_o     <= '0;
         data_o   <= '0;
         syn_o    <= '0;
         err_o    <= 1'b0;
         uncorr_o <= 1'b0;
      end else begin
         vld_o <= vld_i;
         if (vld_i) begin
            cw_o     <= fix_c;
            data_o   <= dat_c;
            syn_o    <= syn_c;
            err_o    <= err_c;
            uncorr_o <= unc_c;
         end
      end
   end
endmodule

// File: rtl/hd13_chk.sv
module hd13_chk #(
   parameter int CW_W  = 13,
   parameter int CHK_W = 4,
   parameter int DAT_W = 9
) (
   input logic             clk,
   input logic             rst,
   input logic             vld_i,
   input logic [CW_W-1:0]  cw_i,
   input logic             vld_o,
   input logic [CW_W-1:0]  cw_o,
   input logic [DAT_W-1:0] data_o,
   input logic [CHK_W-1:0] syn_o,
   input logic             err_o,
   input logic             uncorr_o
);
   logic [DAT_W-1:0] dat_ref;
   always_comb begin
      for (int j = 0; j < DAT_W; j++) dat_ref[j] = cw_o[hd13_pkg::data_pos(j) - 1];
   end

   // R7
   vld_rise_chk: assert property (@(posedge clk) disable iff (rst) vld_i |=> vld_o);
   // R7
   vld_low_chk: assert property (@(posedge clk) disable iff (rst) !vld_i |=> !vld_o);
   // R7
   hold_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> ($stable(cw_o) && $stable(data_o) && $stable(syn_o)
                  && $stable(err_o) && $stable(uncorr_o)));
   // R3
   clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_o && !err_o) |-> (cw_o == $past(cw_i) && syn_o == '0 && !uncorr_o));
   // R4
   single_flip_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_o && err_o && !uncorr_o) |-> ($countones(cw_o ^ $past(cw_i)) == 1));
   // R5
   uncorr_pass_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_o && uncorr_o) |-> (cw_o == $past(cw_i) && err_o));
   // R2
   err_syn_chk: assert property (@(posedge clk) disable iff (rst)
      err_o == (syn_o != '0));
   // R6
   data_map_chk: assert property (@(posedge clk) disable iff (rst) data_o == dat_ref);
   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (!vld_o && cw_o == '0 && data_o == '0 && syn_o == '0 && !err_o && !uncorr_o));
endmodule

bind hamm13_odd_dec hd13_chk #(.CW_W(CW_W), .CHK_W(CHK_W), .DAT_W(DAT_W)) chk_i (
   .clk      (clk),
   .rst      (rst),
   .vld_i    (vld_i),
   .cw_i     (cw_i),
   .vld_o    (vld_o),
   .cw_o     (cw_o),
   .data_o   (data_o),
   .syn_o    (syn_o),
   .err_o    (err_o),
   .uncorr_o (uncorr_o)
);

// File: tb/hamm13_odd_dec_tb.sv
`timescale 1ns/100ps
module hamm13_odd_dec_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        vld_i = 1'b0;
   logic [12:0] cw_i = '0;
   logic        vld_o;
   logic [12:0] cw_o;
   logic [8:0]  data_o;
   logic [3:0]  syn_o;
   logic        err_o;
   logic        uncorr_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   hamm13_odd_dec dut_i (
      .clk(clk), .rst(rst), .vld_i(vld_i), .cw_i(cw_i),
      .vld_o(vld_o), .cw_o(cw_o), .data_o(data_o), .syn_o(syn_o),
      .err_o(err_o), .uncorr_o(uncorr_o)
   );

   typedef struct {
      logic [12:0] cw;
      logic [8:0]  dat;
      logic [3:0]  syn;
      logic        err;
      logic        unc;
      string       tag;
   } exp_t;

   exp_t q[$];
   exp_t held;

   // R6: payload positions, LSB first
   int dpos[9] = '{3, 5, 6, 7, 9, 10, 11, 12, 13};

   function automatic exp_t model(input logic [12:0] rx, input string tag);
      exp_t e;
      int ones;
      int pos;
      // R2: odd-parity checks; even ones count fails
      for (int k = 0; k < 4; k++) begin
         ones = 0;
         for (int p = 1; p <= 13; p++) if (((p >> k) & 1) == 1) ones += int'(rx[p-1]);
         e.syn[k] = (ones % 2 == 0);
      end
      pos = int'(e.syn);
      if (pos >= 1 && pos <= 13) e.cw = rx ^ (13'd1 << (pos - 1));
      else e.cw = rx;
      e.err = (pos != 0);
      e.unc = (pos > 13);
      for (int j = 0; j < 9; j++) e.dat[j] = e.cw[dpos[j]-1];
      e.tag = tag;
      return e;
   endfunction

   function automatic logic [12:0] encode(input logic [8:0] d);
      logic [12:0] c;
      logic [12:0] m;
      c = '0;
      for (int j = 0; j < 9; j++) c[dpos[j]-1] = d[j];
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 13; i++) m[i] = (((i + 1) >> k) & 1) == 1;
         c[(1 << k) - 1] = ~^(c & m);
      end
      return c;
   endfunction

   task automatic push_cw(input logic [12:0] rx, input exp_t e);
      @(negedge clk);
      vld_i = 1'b1;
      cw_i  = rx;
      q.push_back(e);
   endtask

   task automatic send(input logic [12:0] rx, input string tag);
      push_cw(rx, model(rx, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         vld_i = 1'b0;
      end
   endtask

   task automatic compare(input exp_t e);
      checks++;
      if (cw_o !== e.cw || data_o !== e.dat || syn_o !== e.syn ||
          err_o !== e.err || uncorr_o !== e.unc) begin
         errors++;
         $display("FAIL %s: act cw=%b dat=%h syn=%0d err=%b unc=%b exp cw=%b dat=%h syn=%0d err=%b unc=%b",
                  e.tag, cw_o, data_o, syn_o, err_o, uncorr_o,
                  e.cw, e.dat, e.syn, e.err, e.unc);
      end
   endtask

   function automatic exp_t zero_item(input string tag);
      exp_t e;
      e.cw = '0; e.dat = '0; e.syn = '0; e.err = 1'b0; e.unc = 1'b0; e.tag = tag;
      return e;
   endfunction

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst) begin
         held = zero_item("R8 reset state");
      end else if (vld_o) begin
         if (q.size() == 0) begin
            checks++;
            errors++;
            $display("FAIL R7: act vld_o=1 exp vld_o=0 (no word pending)");
         end else begin
            exp_t e;
            e = q.pop_front();
            compare(e);
            held = e;
            held.tag = "R7 hold";
         end
      end else begin
         checks++;
         if (vld_o !== 1'b0) begin
            errors++;
            $display("FAIL R7: act vld_o=%b exp 0", vld_o);
         end
         compare(held);
      end
   end

   initial begin
      exp_t ex;
      logic [12:0] base;
      logic [8:0]  pay[4] = '{9'h000, 9'h1FF, 9'h0A5, 9'h15A};
      repeat (4) @(negedge clk);
      rst = 1'b0;
      idle(2);

      // R1 R2 R4: worked example with fixed expectation
      ex.cw = 13'b0011101101101; ex.dat = 9'b001111101; ex.syn = 4'd7;
      ex.err = 1'b1; ex.unc = 1'b0; ex.tag = "R1 R4 example";
      push_cw(13'b0011100101101, ex);
      idle(2);

      // R3 R6: clean words, back to back
      for (int i = 0; i < 4; i++) send(encode(pay[i]), "R3 R6 clean");
      idle(3);

      // R4: single error at every position
      base = encode(9'h0C3);
      for (int p = 1; p <= 13; p++) send(base ^ (13'd1 << (p - 1)), "R4 single flip");
      idle(2);

      // R5: double errors reaching syndromes 14 and 15
      base = encode(9'h12E);
      send(base ^ 13'b0000010100000, "R5 syndrome 14");
      idle(1);
      send(base ^ 13'b0000011000000, "R5 syndrome 15");
      idle(4);

      // R2: double error aliasing to an in-range syndrome
      send(base ^ 13'b0000000000011, "R2 alias syndrome 3");
      idle(3);

      // R8: reset in mid-run clears outputs
      rst = 1'b1;
      q.delete();
      idle(2);
      @(negedge clk);
      rst = 1'b0;
      idle(3);

      // R7: sparse stream with gaps
      send(encode(9'h055) ^ 13'h0800, "R7 gap 1");
      idle(2);
      send(encode(9'h1AA), "R7 gap 2");
      idle(4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: act running exp finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule